// File: doc/BRIEF.md
# General-Purpose Register File with 16-bit Pointer Pairs

This block holds the working registers of an 8-bit RISC core: thirty-two 8-bit registers with two combinational read ports and one write port. An ALU instruction reads both of its operands and writes its result back in a single clock. A register written at a clock edge shows its new value from that edge onwards. During the cycle of the write, the read ports still show the old value.

The six highest registers also act as three 16-bit address pointers. Registers 26/27 form X, registers 28/29 form Y and registers 30/31 form Z. In each pair the even register is the low byte. A dedicated pointer port selects one of the pointers and presents an effective address for an indirect memory access. It can also add a small unsigned displacement to Y or Z. It can post-increment or pre-decrement the selected pointer in place as one 16-bit quantity, while the normal write port updates any other register in the same cycle. The Z pointer is always available on a separate output that serves as the address for table reads from program memory.

Top module: `gpr_file`

## Requirements
- R1: After reset every register reads 0x00 on both read ports.
- R2: With wr_en high at a rising edge, wr_data is stored in register wr_idx. Each read port returns the register named by its own index combinationally.
- R3: In the cycle in which a register is being written, a read of that register returns its previous value. There is no bypass.
- R4: ptr_sel encodes 0 = X {R27,R26}, 1 = Y {R29,R28}, 2 = Z {R31,R30}, each high byte first. Code 3 selects no pointer: ptr_addr is 0x0000 and no register changes.
- R5: ptr_op encodes 0 = hold, 1 = post-increment, 2 = pre-decrement, 3 = hold. With post-increment, ptr_addr is the current pointer and the pointer becomes pointer+1 at the edge. The carry passes into the high byte, and 0xFFFF wraps to 0x0000.
- R6: With pre-decrement, ptr_addr is pointer-1, and the pointer takes that value at the edge. 0x0000 wraps to 0xFFFF.
- R7: With a hold op, ptr_disp_en high and ptr_sel selecting Y or Z, ptr_addr is the pointer plus the zero-extended 6-bit ptr_disp, modulo 2^16. For X the displacement is ignored. The stored pointer never changes under a hold op.
- R8: With a hold op and ptr_disp_en low, ptr_addr equals the selected pointer.
- R9: If the write port targets a byte of the pointer being updated, the written byte wins. The other byte of that pair still takes its updated value.
- R10: A pointer update and a write to an unrelated register both take effect in the same cycle.
- R11: table_addr always equals the current Z pointer {R31,R30}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 8 | Write data |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z, 3 none) |
| ptr_op | input | 2 | Pointer op (0 hold, 1 post-inc, 2 pre-dec, 3 hold) |
| ptr_disp_en | input | 1 | Add displacement to Y or Z |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address for the indirect access |
| table_addr | output | 16 | Z pointer for program-memory table reads |

## Verification
The hardest case to reach from the ports is a pointer update that wraps across 0xFFFF or 0x0000, or that carries into the high byte, in the same cycle as a write into one byte of that same pair. Random stimulus seldom lines these up. The bench therefore first loads pointers with boundary values through the write port, and then applies the colliding update. It also biases the random write index toward registers 26 to 31 so that overlaps of writes and pointer updates occur often. Every result is read back through the ordinary read ports on the next cycle.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    POP_HOLD    = 2'd0,
    POP_POSTINC = 2'd1,
    POP_PREDEC  = 2'd2,
    POP_RSVD    = 2'd3
  } pop_e;
endpackage

// File: rtl/gpr_bank.sv
`timescale 1ns/1ps
module gpr_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int NUM_PTRS = 3,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int PTR_W    = 2 * DATA_W,
  localparam int PTR_BASE = NUM_REGS - 2 * NUM_PTRS,
  localparam int PSEL_W   = $clog2(NUM_PTRS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             pupd_en,
  input  logic [PSEL_W-1:0]                pupd_pair,
  input  logic [PTR_W-1:0]                 pupd_val,
  input  logic [IDX_W-1:0]                 rd_a_idx,
  input  logic [IDX_W-1:0]                 rd_b_idx,
  output logic [DATA_W-1:0]                rd_a_data,
  output logic [DATA_W-1:0]                rd_b_data,
  output logic [NUM_PTRS-1:0][PTR_W-1:0]   ptr_words
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;
  // per-register events, named for the assertions
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] pt_hit;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [DATA_W-1:0] pt_byte;
    assign wr_hit[gi] = wr_en && (wr_idx == IDX_W'(gi));
    if (gi >= PTR_BASE) begin : g_ptr
      localparam int PAIR = (gi - PTR_BASE) / 2;
      localparam int HALF = (gi - PTR_BASE) % 2;
      assign pt_hit[gi] = pupd_en && (pupd_pair == PSEL_W'(PAIR));
      assign pt_byte    = pupd_val[HALF*DATA_W +: DATA_W];
    end else begin : g_plain
      assign pt_hit[gi] = 1'b0;
      assign pt_byte    = '0;
    end
    // the write port has priority over the pointer update
    assign regs_d[gi] = wr_hit[gi] ? wr_data :
                        pt_hit[gi] ? pt_byte : regs_q[gi];

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[gi] |=> regs_q[gi] == $past(wr_data));
    a_r10_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[gi] && !pt_hit[gi]) |=> $stable(regs_q[gi]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_a_data = regs_q[rd_a_idx];
  assign rd_b_data = regs_q[rd_b_idx];

  for (genvar gp = 0; gp < NUM_PTRS; gp++) begin : g_word
    assign ptr_words[gp] = {regs_q[PTR_BASE + 2*gp + 1], regs_q[PTR_BASE + 2*gp]};
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> regs_q == '0);
endmodule

// File: rtl/gpr_ptr_unit.sv
`timescale 1ns/1ps
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DISP_W   = 6,
  parameter int NUM_PTRS = 3,
  localparam int PTR_W   = 2 * DATA_W,
  localparam int PSEL_W  = $clog2(NUM_PTRS + 1)
) (
  input  logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_words,
  input  logic [PSEL_W-1:0]              sel,
  input  logic [1:0]                     op,
  input  logic                           disp_en,
  input  logic [DISP_W-1:0]              disp,
  output logic [PTR_W-1:0]               addr,
  output logic [PTR_W-1:0]               base,
  output logic                           ev_inc,
  output logic                           ev_dec,
  output logic                           ev_disp,
  output logic                           upd_en,
  output logic [PSEL_W-1:0]              upd_pair,
  output logic [PTR_W-1:0]               upd_val
);
  logic             valid;
  logic [PTR_W-1:0] stepped;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic down);
    return down ? p - PTR_W'(1) : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_offset(input logic [PTR_W-1:0] p,
                                                  input logic [DISP_W-1:0] d);
    return p + PTR_W'(d);
  endfunction

  assign valid = (sel < PSEL_W'(NUM_PTRS));

  always_comb begin
    base = '0;
    for (int k = 0; k < NUM_PTRS; k++)
      if (sel == PSEL_W'(k)) base = ptr_words[k];
  end

  assign ev_inc  = valid && (op == POP_POSTINC);
  assign ev_dec  = valid && (op == POP_PREDEC);
  assign ev_disp = valid && !ev_inc && !ev_dec && disp_en && (sel != PSEL_W'(PSEL_X));

  assign stepped = ptr_step(base, ev_dec);

  always_comb begin
    if (ev_dec)       addr = stepped;
    else if (ev_disp) addr = ptr_offset(base, disp);
    else              addr = base;
  end

  assign upd_en   = ev_inc || ev_dec;
  assign upd_pair = sel;
  assign upd_val  = stepped;
endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int DISP_W   = 6,
  localparam int NUM_PTRS = 3,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int PTR_W    = 2 * DATA_W,
  localparam int PSEL_W   = $clog2(NUM_PTRS + 1),
  localparam int PTR_BASE = NUM_REGS - 2 * NUM_PTRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PSEL_W-1:0] ptr_sel,
  input  logic [1:0]        ptr_op,
  input  logic              ptr_disp_en,
  input  logic [DISP_W-1:0] ptr_disp,
  output logic [PTR_W-1:0]  ptr_addr,
  output logic [PTR_W-1:0]  table_addr
);
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_words;
  logic [PTR_W-1:0]               ptr_base;
  logic                           ev_inc, ev_dec, ev_disp;
  logic                           upd_en;
  logic [PSEL_W-1:0]              upd_pair;
  logic [PTR_W-1:0]               upd_val;
  logic                           wr_in_sel_pair;

  gpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_PTRS(NUM_PTRS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .pupd_en   (upd_en),
    .pupd_pair (upd_pair),
    .pupd_val  (upd_val),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .ptr_words (ptr_words)
  );

  gpr_ptr_unit #(.DATA_W(DATA_W), .DISP_W(DISP_W), .NUM_PTRS(NUM_PTRS)) u_ptr (
    .ptr_words (ptr_words),
    .sel       (ptr_sel),
    .op        (ptr_op),
    .disp_en   (ptr_disp_en),
    .disp      (ptr_disp),
    .addr      (ptr_addr),
    .base      (ptr_base),
    .ev_inc    (ev_inc),
    .ev_dec    (ev_dec),
    .ev_disp   (ev_disp),
    .upd_en    (upd_en),
    .upd_pair  (upd_pair),
    .upd_val   (upd_val)
  );

  // table reads always address through the last pointer
  assign table_addr = ptr_words[NUM_PTRS-1];

  // write that lands in either byte of the selected pair
  assign wr_in_sel_pair = wr_en && (wr_idx >= IDX_W'(PTR_BASE)) &&
                          ((wr_idx - IDX_W'(PTR_BASE)) >> 1) == IDX_W'(ptr_sel);

  a_r5_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inc && !wr_in_sel_pair) |=> ptr_words[$past(upd_pair)] == $past(ptr_addr) + PTR_W'(1));
  a_r6_predec_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dec && !wr_in_sel_pair) |=> ptr_words[$past(upd_pair)] == $past(ptr_addr));
  a_r7_disp_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_disp && !wr_en) |=> $stable(ptr_words));
  a_r11_table_is_z: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_W'(PSEL_Z) && ptr_op == POP_HOLD && !ptr_disp_en) |-> ptr_addr == table_addr);
  a_r4_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_W'(PSEL_NONE) && !wr_en) |=> $stable(ptr_words));
endmodule

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en, ptr_disp_en;
  logic [1:0]  ptr_sel, ptr_op;
  logic [5:0]  ptr_disp;
  logic [15:0] ptr_addr, table_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [32];

  always #5 clk = ~clk;

  gpr_file dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_op(ptr_op),
    .ptr_disp_en(ptr_disp_en), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr), .table_addr(table_addr)
  );

  function automatic logic [15:0] mptr(input int s);
    return {mdl[27 + 2*s], mdl[26 + 2*s]};
  endfunction

  function automatic logic [15:0] exp_addr(input logic [1:0] s, input logic [1:0] op,
                                           input logic de, input logic [5:0] d);
    logic [15:0] p;
    if (s == 2'd3) return 16'h0000;
    p = mptr(int'(s));
    if (op == 2'd2) return p - 16'd1;
    if (op == 2'd1) return p;
    if (de && s != 2'd0) return p + {10'd0, d};
    return p;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] wi, input logic [7:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb,
                      input logic [1:0] s, input logic [1:0] op,
                      input logic de, input logic [5:0] d, input string rtag = "");
    string ta, tb, tp;
    logic [15:0] np;
    wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    ptr_sel = s; ptr_op = op; ptr_disp_en = de; ptr_disp = d;
    #1;
    ta = (rtag != "") ? rtag : ((we && wi == ra) ? "R3" : "R2");
    tb = (rtag != "") ? rtag : ((we && wi == rb) ? "R3" : "R2");
    chk(ta, {8'h00, rd_a_data}, {8'h00, mdl[ra]});
    chk(tb, {8'h00, rd_b_data}, {8'h00, mdl[rb]});
    if (s == 2'd3)                 tp = "R4";
    else if (op == 2'd1)           tp = "R5";
    else if (op == 2'd2)           tp = "R6";
    else if (de)                   tp = "R7";
    else                           tp = "R8";
    chk(tp, ptr_addr, exp_addr(s, op, de, d));
    chk("R11", table_addr, mptr(2));
    @(posedge clk);
    if (s != 2'd3 && (op == 2'd1 || op == 2'd2)) begin
      np = (op == 2'd1) ? mptr(int'(s)) + 16'd1 : mptr(int'(s)) - 16'd1;
      mdl[26 + 2*s] = np[7:0];
      mdl[27 + 2*s] = np[15:8];
    end
    if (we) mdl[wi] = wd;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] wi, input logic [7:0] wd);
    step(1'b1, wi, wd, 5'd0, 5'd1, 2'd3, 2'd0, 1'b0, 6'd0);
  endtask

  task automatic rd(input logic [4:0] ra, input logic [4:0] rb, input string tag);
    step(1'b0, 5'd0, 8'h00, ra, rb, 2'd3, 2'd0, 1'b0, 6'd0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [4:0] rw;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
    ptr_sel = 2'd3; ptr_op = 2'd0; ptr_disp_en = 1'b0; ptr_disp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything clear after reset
    for (int i = 0; i < 16; i++) rd(5'(2*i), 5'(2*i + 1), "R1");

    // R2 / R3: write then read; same-cycle read shows old value
    wr(5'd7, 8'hA5);
    step(1'b1, 5'd7, 8'h3C, 5'd7, 5'd7, 2'd3, 2'd0, 1'b0, 6'd0, "R3");
    rd(5'd7, 5'd0, "R2");

    // R5: Z at 0xFFFF post-increments to 0x0000
    wr(5'd30, 8'hFF); wr(5'd31, 8'hFF);
    step(1'b0, 5'd0, 8'h00, 5'd30, 5'd31, 2'd2, 2'd1, 1'b0, 6'd0);
    rd(5'd30, 5'd31, "R5");
    // R5: carry into high byte, Y 0x12FF -> 0x1300
    wr(5'd28, 8'hFF); wr(5'd29, 8'h12);
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd1, 2'd1, 1'b0, 6'd0);
    rd(5'd28, 5'd29, "R5");

    // R6: X at 0x0000 pre-decrements to 0xFFFF
    wr(5'd26, 8'h00); wr(5'd27, 8'h00);
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd0, 2'd2, 1'b0, 6'd0);
    rd(5'd26, 5'd27, "R6");

    // R7: displacement wraps, pointer unchanged; ignored on X
    wr(5'd28, 8'hF0); wr(5'd29, 8'hFF);
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd1, 2'd0, 1'b1, 6'h3F);
    rd(5'd28, 5'd29, "R7");
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd0, 2'd3, 1'b1, 6'h21);
    rd(5'd26, 5'd27, "R7");

    // R8: plain pointer read
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd1, 2'd0, 1'b0, 6'h15);

    // R9: write into low byte wins, high byte still carries
    wr(5'd30, 8'hFF); wr(5'd31, 8'h00);
    step(1'b1, 5'd30, 8'h55, 5'd0, 5'd0, 2'd2, 2'd1, 1'b0, 6'd0);
    rd(5'd30, 5'd31, "R9");
    // R9: write into high byte during pre-decrement
    step(1'b1, 5'd31, 8'hC3, 5'd0, 5'd0, 2'd2, 2'd2, 1'b0, 6'd0);
    rd(5'd30, 5'd31, "R9");

    // R10: update X and write R3 together
    step(1'b1, 5'd3, 8'h9C, 5'd0, 5'd0, 2'd0, 2'd1, 1'b0, 6'd0);
    rd(5'd3, 5'd26, "R10");
    rd(5'd27, 5'd3, "R10");

    // R4: code 3 selects nothing even with an update op
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd3, 2'd1, 1'b0, 6'd0);
    step(1'b0, 5'd0, 8'h00, 5'd0, 5'd0, 2'd3, 2'd2, 1'b1, 6'd9);
    rd(5'd26, 5'd27, "R4"); rd(5'd28, 5'd29, "R4"); rd(5'd30, 5'd31, "R4");

    // constrained random, write index biased toward the pointer pairs
    for (int i = 0; i < 3000; i++) begin
      rw = ($urandom % 2 == 0) ? 5'(26 + $urandom % 6) : 5'($urandom % 32);
      step(1'($urandom % 4 != 0), rw, 8'($urandom),
           5'($urandom % 32), 5'(($urandom % 2 == 0) ? 26 + $urandom % 6 : $urandom % 32),
           2'($urandom), 2'($urandom), 1'($urandom), 6'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule